// File: doc/BRIEF.md
# Configurable NaN Classifier and Quieter

This combinational unit inspects one floating-point operand in half, single or double precision and reports whether it is a quiet NaN, a signaling NaN, or no NaN at all. The operand is right-aligned on a 64-bit bus, and a two-bit format select picks the width. The unit also returns a quieted copy of the operand and the canonical default NaN for the chosen format. Both of these are right-aligned and zero-extended to 64 bits.

Two configuration inputs shape the decision. The polarity input chooses between two conventions. In the modern one, a set top fraction bit means quiet. In the legacy one, a set top fraction bit means signaling. The no-signaling input makes the unit treat every NaN as quiet. Execution pipelines use the unit ahead of result selection, to raise the invalid flag and to hand a correctly quieted NaN to the writeback path.

Top module: `nanq_unit`

## Requirements
- R1: `fmt_sel` encodes 2'b00 as binary16 (operand bits [15:0]), 2'b01 as binary32 (bits [31:0]) and 2'b10 as binary64 (bits [63:0]). Operand bits above the selected width do not affect any output. `quieted` and `dflt_nan` carry zeros above the selected width.
- R2: With `legacy_pol`=0 and `no_snan_mode`=0, a value with an all-ones exponent and the top fraction bit set is reported as a quiet NaN. A value with an all-ones exponent, the top fraction bit clear and the other fraction bits nonzero is reported as a signaling NaN. Infinities and all finite values raise neither flag.
- R3: With `legacy_pol`=1 and `no_snan_mode`=0, the roles swap. An all-ones exponent with the top fraction bit set is signaling. An all-ones exponent with the top fraction bit clear and the remaining fraction bits nonzero is quiet.
- R4: With `no_snan_mode`=1, `is_snan` is 0 for every input, and `is_qnan` is 1 exactly when the value is a NaN. This holds under either polarity.
- R5: `is_nan` is 1 exactly for an all-ones exponent with a nonzero fraction, and equals `is_qnan` OR `is_snan`. `is_qnan` and `is_snan` are never both 1.
- R6: With `legacy_pol`=0, quieting a signaling NaN sets the top fraction bit and keeps the sign, exponent and all other fraction bits.
- R7: With `legacy_pol`=1, quieting a signaling NaN yields the default NaN of the selected format.
- R8: For any input that is not reported as a signaling NaN, `quieted` equals the operand's bits of the selected width.
- R9: `dflt_nan` has sign 0 and an all-ones exponent in both conventions. With `legacy_pol`=0 its fraction has only the top bit set. With `legacy_pol`=1 its fraction has every bit set except the top one. For example, the binary16 default NaN is 0x7E00 with `legacy_pol`=0 and 0x7DFF with `legacy_pol`=1.
- R10: `fmt_sel`=2'b11 is reserved. All three flags are 0, `quieted` equals the whole 64-bit operand, and `dflt_nan` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmt_sel | input | 2 | Operand format select |
| legacy_pol | input | 1 | 1: top fraction bit set means signaling |
| no_snan_mode | input | 1 | 1: every NaN is treated as quiet |
| operand | input | 64 | Operand, right-aligned |
| is_qnan | output | 1 | Operand is a quiet NaN |
| is_snan | output | 1 | Operand is a signaling NaN |
| is_nan | output | 1 | Operand is any NaN |
| quieted | output | 64 | Quieted copy of the operand, right-aligned |
| dflt_nan | output | 64 | Default NaN of the selected format, right-aligned |

## Verification
Every binary16 encoding is applied under all four combinations of polarity and no-signaling mode, with random garbage above bit 15. This separates quiet from signaling NaNs, infinities from NaNs, and the one-bit boundary between payloads that are zero and nonzero. Binary32 and binary64 are driven in two ways. The first is walking single-bit and all-but-one fraction patterns under an all-ones exponent, which exposes an off-by-one in the fraction index. The second is random values, half of them forced into the NaN region. A few decoded constants pin down the quieting result, the default patterns under each polarity, and the reserved format, which must pass the whole bus through.

// File: rtl/nanq_pkg.sv
// Shared constants and types for the NaN classifier.
// Assumes the IEEE binary interchange layout: sign, biased exponent, fraction.
package nanq_pkg;

    localparam int BUS_W   = 64;
    localparam int N_LANES = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    // Per-lane result, zero-extended to the bus width.
    typedef struct packed {
        logic             nan;
        logic             qnan;
        logic             snan;
        logic [BUS_W-1:0] quiet;
        logic [BUS_W-1:0] dflt;
    } lane_res_t;

    // Exponent width of lane i (lane index equals the format code).
    function automatic int lane_exp_w(input int i);
        case (i)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    // Fraction width of lane i.
    function automatic int lane_frac_w(input int i);
        case (i)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    // Total encoding width of lane i.
    function automatic int lane_tot_w(input int i);
        return 1 + lane_exp_w(i) + lane_frac_w(i);
    endfunction

endpackage

// File: rtl/nanq_fields.sv
// Field decoder: reduces an encoding to the few facts the NaN logic needs.
// Assumes FRAC_W >= 2 so that a payload below the top fraction bit exists.
module nanq_fields #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
    input  logic [TOT_W-1:0] enc,
    output logic             exp_ones,
    output logic             frac_msb,
    output logic             rest_nz
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              sign_unused;

    // Split the encoding into its fields.
    assign {sign_unused, exp_f, frac_f} = enc;

    // Reduce the fields to exponent saturation, top fraction bit and payload.
    always_comb begin
        exp_ones = &exp_f;
        frac_msb = frac_f[FRAC_W-1];
        rest_nz  = |frac_f[FRAC_W-2:0];
    end

endmodule

// File: rtl/nanq_decide.sv
// Classifier: turns the decoded fields into quiet/signaling/any-NaN flags
// under the selected polarity and signaling-disable mode.
module nanq_decide (
    input  logic exp_ones,
    input  logic frac_msb,
    input  logic rest_nz,
    input  logic legacy_pol,
    input  logic no_snan_mode,
    output logic nan,
    output logic qnan,
    output logic snan
);

    logic msb_kind;
    logic low_kind;

    // Kind marked by a set top bit vs. a clear top bit with nonzero payload.
    always_comb begin
        nan      = exp_ones & (frac_msb | rest_nz);
        msb_kind = exp_ones & frac_msb;
        low_kind = exp_ones & ~frac_msb & rest_nz;
    end

    // Map the two kinds onto quiet/signaling according to the configuration.
    always_comb begin
        if (no_snan_mode) begin
            qnan = nan;
            snan = 1'b0;
        end else if (legacy_pol) begin
            qnan = low_kind;
            snan = msb_kind;
        end else begin
            qnan = msb_kind;
            snan = low_kind;
        end
    end

endmodule

// File: rtl/nanq_lane.sv
// One format lane: classifies an encoding of fixed width and forms the
// quieted value and the default NaN, both zero-extended to BUS_W.
// Assumes BUS_W >= TOT_W.
module nanq_lane
    import nanq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
    input  logic [TOT_W-1:0] enc,
    input  logic             legacy_pol,
    input  logic             no_snan_mode,
    output lane_res_t        res
);

    logic              exp_ones;
    logic              frac_msb;
    logic              rest_nz;
    logic              nan;
    logic              qnan;
    logic              snan;
    logic [TOT_W-1:0]  dflt_enc;
    logic [TOT_W-1:0]  quiet_enc;
    logic [FRAC_W-1:0] dflt_frac;

    nanq_fields #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fields (
        .enc      (enc),
        .exp_ones (exp_ones),
        .frac_msb (frac_msb),
        .rest_nz  (rest_nz)
    );

    nanq_decide u_decide (
        .exp_ones     (exp_ones),
        .frac_msb     (frac_msb),
        .rest_nz      (rest_nz),
        .legacy_pol   (legacy_pol),
        .no_snan_mode (no_snan_mode),
        .nan          (nan),
        .qnan         (qnan),
        .snan         (snan)
    );

    // Default NaN: positive, saturated exponent, polarity-dependent fraction.
    always_comb begin
        dflt_frac = '0;
        if (legacy_pol) begin
            dflt_frac           = '1;
            dflt_frac[FRAC_W-1] = 1'b0;
        end else begin
            dflt_frac[FRAC_W-1] = 1'b1;
        end
        dflt_enc = {1'b0, {EXP_W{1'b1}}, dflt_frac};
    end

    // Quieting: set the top bit, or substitute the default under legacy polarity.
    always_comb begin
        quiet_enc = enc;
        if (snan) begin
            if (legacy_pol) begin
                quiet_enc = dflt_enc;
            end else begin
                quiet_enc[FRAC_W-1] = 1'b1;
            end
        end
    end

    // Pack the lane result, zero-extending to the bus width.
    always_comb begin
        res              = '0;
        res.nan          = nan;
        res.qnan         = qnan;
        res.snan         = snan;
        res.quiet[TOT_W-1:0] = quiet_enc;
        res.dflt[TOT_W-1:0]  = dflt_enc;
    end

endmodule

// File: rtl/nanq_unit.sv
// Top: NaN classifier and quieter for binary16/32/64 operands.
// One lane per format is instantiated and the selected one is forwarded.
// Purely combinational; operand is right-aligned on the bus.
module nanq_unit
    import nanq_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic [1:0]   fmt_sel,
    input  logic         legacy_pol,
    input  logic         no_snan_mode,
    input  logic [W-1:0] operand,
    output logic         is_qnan,
    output logic         is_snan,
    output logic         is_nan,
    output logic [W-1:0] quieted,
    output logic [W-1:0] dflt_nan
);

    lane_res_t lane_res [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        nanq_lane #(
            .EXP_W  (lane_exp_w(g)),
            .FRAC_W (lane_frac_w(g))
        ) u_lane (
            .enc          (operand[lane_tot_w(g)-1:0]),
            .legacy_pol   (legacy_pol),
            .no_snan_mode (no_snan_mode),
            .res          (lane_res[g])
        );
    end

    // Forward the lane chosen by the format select; reserved code passes through.
    always_comb begin
        is_qnan  = 1'b0;
        is_snan  = 1'b0;
        is_nan   = 1'b0;
        quieted  = operand;
        dflt_nan = '0;
        case (fmt_e'(fmt_sel))
            FMT_HALF, FMT_SINGLE, FMT_DOUBLE: begin
                is_qnan  = lane_res[fmt_sel].qnan;
                is_snan  = lane_res[fmt_sel].snan;
                is_nan   = lane_res[fmt_sel].nan;
                quieted  = lane_res[fmt_sel].quiet[W-1:0];
                dflt_nan = lane_res[fmt_sel].dflt[W-1:0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nanq_unit_chk.sv
// Checker for nanq_unit: relates the flags to each other and the data
// outputs to the operand. Attached by the bind below.
module nanq_unit_chk #(
    parameter int W = 64
) (
    input logic [1:0]   fmt_sel,
    input logic         legacy_pol,
    input logic         no_snan_mode,
    input logic [W-1:0] operand,
    input logic         is_qnan,
    input logic         is_snan,
    input logic         is_nan,
    input logic [W-1:0] quieted,
    input logic [W-1:0] dflt_nan
);

    logic [W-1:0] fmt_mask;
    logic [W-1:0] sign_bit;

    // Width mask and sign position of the selected format.
    always_comb begin
        case (fmt_sel)
            2'b00:   begin fmt_mask = W'(64'hFFFF);      sign_bit = W'(64'h8000); end
            2'b01:   begin fmt_mask = W'(64'hFFFF_FFFF); sign_bit = W'(64'h8000_0000); end
            default: begin fmt_mask = '1;                sign_bit = {1'b1, {(W-1){1'b0}}}; end
        endcase
    end

    // Flag and data relations that must hold for every input.
    always_comb begin
        // R5
        qs_exclusive_chk: assert (!(is_qnan && is_snan))
            else $error("quiet and signaling both set");
        // R5
        nan_union_chk: assert (is_nan == (is_qnan || is_snan))
            else $error("is_nan disagrees with kind flags");
        // R4
        nosnan_chk: assert (!(no_snan_mode && is_snan))
            else $error("signaling reported in no-signaling mode");
        if (fmt_sel != 2'b11) begin
            // R1
            upper_zero_chk: assert (((quieted | dflt_nan) & ~fmt_mask) == '0)
                else $error("bits above format width not zero");
            // R8
            if (!is_snan) begin
                passthru_chk: assert (quieted == (operand & fmt_mask))
                    else $error("non-signaling input altered");
            end
            // R7
            if (is_snan && legacy_pol) begin
                legacy_quiet_chk: assert (quieted == dflt_nan)
                    else $error("legacy quieting not default NaN");
            end
            // R9
            dflt_sign_chk: assert ((dflt_nan & sign_bit) == '0)
                else $error("default NaN negative");
        end else begin
            // R10
            rsvd_chk: assert (!is_nan && quieted == operand && dflt_nan == '0)
                else $error("reserved format not passive");
        end
    end

endmodule

bind nanq_unit nanq_unit_chk #(.W(W)) u_chk (
    .fmt_sel      (fmt_sel),
    .legacy_pol   (legacy_pol),
    .no_snan_mode (no_snan_mode),
    .operand      (operand),
    .is_qnan      (is_qnan),
    .is_snan      (is_snan),
    .is_nan       (is_nan),
    .quieted      (quieted),
    .dflt_nan     (dflt_nan)
);

// File: tb/tb_nanq_unit.sv
// Bench for nanq_unit: exhaustive binary16 sweep under every configuration,
// structured and random binary32/binary64 sweeps, and decoded constants.
module tb_nanq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        legacy_pol = 1'b0;
    logic        no_snan_mode = 1'b0;
    logic [63:0] operand = '0;
    logic        is_qnan;
    logic        is_snan;
    logic        is_nan;
    logic [63:0] quieted;
    logic [63:0] dflt_nan;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    nanq_unit dut (
        .fmt_sel      (fmt_sel),
        .legacy_pol   (legacy_pol),
        .no_snan_mode (no_snan_mode),
        .operand      (operand),
        .is_qnan      (is_qnan),
        .is_snan      (is_snan),
        .is_nan       (is_nan),
        .quieted      (quieted),
        .dflt_nan     (dflt_nan)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: got cycles=%0d expected < %0d", cycles, WDOG_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [63:0] mk(input int n);
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    // Reference model built from the requirement text (threshold comparisons).
    task automatic ref_eval(input logic [1:0] f, input logic leg, input logic ns,
                            input logic [63:0] op,
                            output logic q, output logic s, output logic n,
                            output logic [63:0] qv, output logic [63:0] dv);
        int e;
        int fr;
        int w;
        logic [63:0] v;
        logic [63:0] sh;
        logic [63:0] thr;
        logic hi_q;
        logic hi_s;
        if (f == 2'b11) begin
            q = 0; s = 0; n = 0; qv = op; dv = '0;     // R10
            return;
        end
        e  = (f == 2'b00) ? 5 : (f == 2'b01) ? 8 : 11;
        fr = (f == 2'b00) ? 10 : (f == 2'b01) ? 23 : 52;
        w  = 1 + e + fr;
        v  = op & mk(w);                                // R1
        sh = (v << 1) & mk(w);
        thr = mk(w) & ~mk(w - e - 1);
        hi_q = (sh >= thr);
        hi_s = (((v >> (fr - 1)) & mk(e + 1)) == (mk(e + 1) - 64'd1)) && ((v & mk(fr - 1)) != 0);
        n = ((v & mk(w - 1)) > (mk(e) << fr));          // R5
        if (ns) begin q = n; s = 0; end                 // R4
        else if (leg) begin q = hi_s; s = hi_q; end     // R3
        else begin q = hi_q; s = hi_s; end              // R2
        dv = leg ? ((mk(e) << fr) | mk(fr - 1)) : ((mk(e) << fr) | (64'd1 << (fr - 1)));  // R9
        if (s) qv = leg ? dv : (v | (64'd1 << (fr - 1)));   // R6 R7
        else   qv = v;                                  // R8
    endtask

    task automatic apply_chk(input logic [1:0] f, input logic leg, input logic ns,
                             input logic [63:0] op, input string tag);
        logic q;
        logic s;
        logic n;
        logic [63:0] qv;
        logic [63:0] dv;
        fmt_sel = f; legacy_pol = leg; no_snan_mode = ns; operand = op;
        #1;
        ref_eval(f, leg, ns, op, q, s, n, qv, dv);
        total = total + 1;
        if (is_qnan !== q || is_snan !== s || is_nan !== n || quieted !== qv || dflt_nan !== dv) begin
            bad = bad + 1;
            $display("FAIL %s fmt=%0d leg=%0b ns=%0b op=%h: got q=%b s=%b n=%b quiet=%h dflt=%h expected q=%b s=%b n=%b quiet=%h dflt=%h",
                     tag, f, leg, ns, op, is_qnan, is_snan, is_nan, quieted, dflt_nan, q, s, n, qv, dv);
        end
    endtask

    function automatic string cfg_tag(input logic leg, input logic ns);
        if (ns) return "R4";
        if (leg) return "R3";
        return "R2";
    endfunction

    // Fixed-value check with hand-decoded expectations.
    task automatic const_chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: zero operand, binary16, modern polarity.
        #1;
        const_chk("reset flags R5", {61'd0, is_qnan, is_snan, is_nan}, 64'd0);
        const_chk("reset dflt R9", dflt_nan, 64'h7E00);

        // Decoded constants.
        apply_chk(2'b01, 1'b0, 1'b0, 64'h7F80_0001, "R6");
        const_chk("R6 sp quiet", quieted, 64'h7FC0_0001);
        apply_chk(2'b01, 1'b1, 1'b0, 64'hFFC0_0000, "R7");
        const_chk("R7 sp legacy quiet", quieted, 64'h7FBF_FFFF);
        apply_chk(2'b10, 1'b0, 1'b0, 64'h0, "R9");
        const_chk("R9 dp dflt", dflt_nan, 64'h7FF8_0000_0000_0000);
        apply_chk(2'b00, 1'b1, 1'b0, 64'h0, "R9");
        const_chk("R9 hp legacy dflt", dflt_nan, 64'h7DFF);
        apply_chk(2'b00, 1'b0, 1'b0, 64'hDEAD_BEEF_1234_7C00, "R1");
        const_chk("R1 hp inf upper bits", {61'd0, is_qnan, is_snan, is_nan}, 64'd0);
        apply_chk(2'b11, 1'b0, 1'b0, 64'h7FF0_0000_0000_0001, "R10");
        const_chk("R10 reserved pass", quieted, 64'h7FF0_0000_0000_0001);

        // Exhaustive binary16 under all configurations with noisy upper bits.
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int i = 0; i < 65536; i++) begin
                logic [63:0] op;
                op = {$urandom(), $urandom()};
                op[15:0] = i[15:0];
                apply_chk(2'b00, cfg[0], cfg[1], op, cfg_tag(cfg[0], cfg[1]));
            end
        end

        // Structured binary32/binary64 fraction patterns under a saturated exponent.
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int b = 0; b < 52; b++) begin
                if (b < 23) begin
                    apply_chk(2'b01, cfg[0], cfg[1], 64'h7F80_0000 | (64'd1 << b), cfg_tag(cfg[0], cfg[1]));
                    apply_chk(2'b01, cfg[0], cfg[1], 64'hFFFF_FFFF & ~(64'd1 << b), cfg_tag(cfg[0], cfg[1]));
                end
                apply_chk(2'b10, cfg[0], cfg[1], 64'hFFF0_0000_0000_0000 | (64'd1 << b), cfg_tag(cfg[0], cfg[1]));
                apply_chk(2'b10, cfg[0], cfg[1], 64'h7FFF_FFFF_FFFF_FFFF & ~(64'd1 << b), cfg_tag(cfg[0], cfg[1]));
            end
            apply_chk(2'b01, cfg[0], cfg[1], 64'h7F80_0000, "R5 inf");
            apply_chk(2'b10, cfg[0], cfg[1], 64'hFFF0_0000_0000_0000, "R5 inf");
        end

        // Random binary32/binary64 and reserved, half forced into NaN space.
        for (int k = 0; k < 6000; k++) begin
            logic [63:0] op;
            logic [1:0]  f;
            logic        leg;
            logic        ns;
            op  = {$urandom(), $urandom()};
            f   = 2'(k % 3 == 2 ? 2'b11 : (k % 3 == 0 ? 2'b01 : 2'b10));
            leg = 1'($urandom());
            ns  = ($urandom() % 4) == 0;
            if (k % 2 == 0) begin
                if (f == 2'b01) op[30:23] = '1;
                if (f == 2'b10) op[62:52] = '1;
            end
            apply_chk(f, leg, ns, op, (f == 2'b11) ? "R10" : cfg_tag(leg, ns));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule